// File: doc/BRIEF.md
# Handshaked Sequential Memory with Configurable Latency

This block is a single-port synchronous word store. Reads and writes are each started by a request strobe and finished by a one-cycle done pulse. How many cycles lie between the two is set by two compile-time parameters, one per direction. With both set to one, it behaves like a small single-cycle RAM. With larger values, it models a large memory assembled from many RAM tiles, where the extra pipeline stages absorb the wiring delay between tiles. A client must wait for the done pulse rather than count cycles.

A client raises `rd_start` with an address, or `wr_start` with an address and a data word, for one cycle while `busy` is low. Only one operation is in flight at any time. The address, the data word and the operation type are latched when the request is accepted. Read data is valid from the `rd_done` cycle onward and is held there until the next read is accepted.

Top module: `hsm_mem`

## Requirements
- R1: A read accepted in cycle c (`rd_start` high while `busy` is low) gives `rd_done` high in cycle c+READ_LATENCY, and in that cycle `rdata` equals the word stored at the latched address.
- R2: A write accepted in cycle c gives `wr_done` high in cycle c+WRITE_LATENCY. The array holds the new word from that cycle on, so any read accepted afterwards returns it.
- R3: Each done pulse lasts exactly one cycle, and `rd_done` and `wr_done` are never high together.
- R4: `busy` is high from the cycle after acceptance through the done cycle, and is low in the cycle after the done pulse. A request that arrives while `busy` is high is ignored: it produces no done pulse and does not change the array.
- R5: When `rd_start` and `wr_start` are both high in an idle cycle, the write is performed and the read is dropped (no `rd_done` follows).
- R6: Changes on `addr` and `wdata` after acceptance have no effect on the operation in flight.
- R7: `rdata` changes only in a cycle where `rd_done` is high, so it stays stable across later writes until the next read completes.
- R8: A synchronous reset `rst` clears `busy`, both done outputs and `rdata` (to 0) and cancels any operation in flight. It leaves the stored words unchanged.
- R9: READ_LATENCY and WRITE_LATENCY are each at least 1 and are checked at elaboration. A build with both set to 3 adds exactly two cycles to every access compared with the 1/1 build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_start | input | 1 | Read request strobe |
| wr_start | input | 1 | Write request strobe, wins over a simultaneous read |
| addr | input | ADDR_W | Word address, latched on acceptance |
| wdata | input | DATA_W | Write data, latched on acceptance |
| rdata | output | DATA_W | Read data, valid from the `rd_done` cycle |
| rd_done | output | 1 | One-cycle pulse marking read completion |
| wr_done | output | 1 | One-cycle pulse marking write commit |
| busy | output | 1 | An operation is in flight |

## Verification
The latency and pulse assertions assume that the client raises a request strobe and then waits for the matching done pulse. The block can only enforce this with its one-in-flight rule, so some stimulus is sent into a busy window on purpose to check that it is dropped. The stable-data assertion assumes that `rdata` starts from its reset value. For this reason the bench holds `rst` high from time zero for several cycles, and it drives every input at the falling edge so that nothing changes at the sampling edge. The same stimulus runs against a 1/1 build and a 3/3 build, and the measured latencies are compared with each build's parameters.

// File: rtl/hsm_pkg.sv
package hsm_pkg;
   typedef enum logic {
      HSM_OP_RD = 1'b0,
      HSM_OP_WR = 1'b1
   } hsm_op_e;
endpackage

// File: rtl/hsm_delay.sv
// Fixed-length pulse delay: fin follows go by LAT-1 registered stages.
module hsm_delay #(
   parameter int LAT = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic go,
   output logic fin
);
   if (LAT < 1) begin : g_bad_lat
      $error("hsm_delay: LAT must be at least 1");
   end

   if (LAT == 1) begin : g_direct
      assign fin = go;
   end else begin : g_pipe
      localparam int STAGES = LAT - 1;
      logic [STAGES-1:0] sr;

      always_ff @(posedge clk) begin
         if (rst) sr[0] <= 1'b0;
         else     sr[0] <= go;
      end

      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) sr[i] <= 1'b0;
            else     sr[i] <= sr[i-1];
         end
      end

      assign fin = sr[STAGES-1];

      // R4: the one-in-flight rule means at most one token in the pipe
      a_r4_single_token: assert property (@(posedge clk) disable iff (rst)
         $onehot0(sr));
   end
endmodule

// File: rtl/hsm_array.sv
// Word storage with one write port and one registered read port.
module hsm_array #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // contents are deliberately not reset
   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rst)     rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end

   // R3: a read and a write never complete on the same edge
   a_r3_port_excl: assert property (@(posedge clk) disable iff (rst)
      !(we && re));
endmodule

// File: rtl/hsm_ctrl.sv
// Acceptance, request capture, busy tracking.
module hsm_ctrl
   import hsm_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int RD_LAT = 1,
   parameter int WR_LAT = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_start,
   input  logic              wr_start,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_done,
   input  logic              wr_done,
   output logic              accept,
   output hsm_op_e           acc_op,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              busy
);
   localparam int MAX_LAT = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
   localparam int AGE_W   = $clog2(MAX_LAT + 2);

   logic             done_any;
   logic [AGE_W-1:0] age;

   assign done_any = rd_done | wr_done;
   assign accept   = !busy && (rd_start || wr_start);
   assign acc_op   = wr_start ? HSM_OP_WR : HSM_OP_RD;

   always_ff @(posedge clk) begin
      if (rst)           busy <= 1'b0;
      else if (accept)   busy <= 1'b1;
      else if (done_any) busy <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         addr_q  <= addr;
         wdata_q <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)         age <= '0;
      else if (accept) age <= AGE_W'(1);
      else if (busy)   age <= age + AGE_W'(1);
      else             age <= '0;
   end

   // R1: read completes exactly RD_LAT cycles after acceptance
   a_r1_rd_latency: assert property (@(posedge clk) disable iff (rst)
      rd_done |-> (age == AGE_W'(RD_LAT)));
   // R2: write completes exactly WR_LAT cycles after acceptance
   a_r2_wr_latency: assert property (@(posedge clk) disable iff (rst)
      wr_done |-> (age == AGE_W'(WR_LAT)));
   // R4: busy holds until a done pulse
   a_r4_busy_hold: assert property (@(posedge clk) disable iff (rst)
      (busy && !done_any) |=> busy);
   // R4: done pulses only inside a busy window
   a_r4_done_in_busy: assert property (@(posedge clk) disable iff (rst)
      done_any |-> busy);
endmodule

// File: rtl/hsm_mem.sv
module hsm_mem
   import hsm_pkg::*;
#(
   parameter int ADDR_W        = 6,
   parameter int DATA_W        = 32,
   parameter int READ_LATENCY  = 1,
   parameter int WRITE_LATENCY = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_start,
   input  logic              wr_start,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rd_done,
   output logic              wr_done,
   output logic              busy
);
   // R9: latency bounds
   if (READ_LATENCY < 1) begin : g_bad_rl
      $error("hsm_mem: READ_LATENCY must be at least 1");
   end
   if (WRITE_LATENCY < 1) begin : g_bad_wl
      $error("hsm_mem: WRITE_LATENCY must be at least 1");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_w
      $error("hsm_mem: widths must be positive");
   end

   logic              accept;
   hsm_op_e           acc_op;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              rd_go, wr_go, rd_fin, wr_fin;
   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic [DATA_W-1:0] wr_word;

   hsm_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .RD_LAT(READ_LATENCY), .WR_LAT(WRITE_LATENCY)
   ) u_ctrl (
      .clk(clk), .rst(rst),
      .rd_start(rd_start), .wr_start(wr_start),
      .addr(addr), .wdata(wdata),
      .rd_done(rd_done), .wr_done(wr_done),
      .accept(accept), .acc_op(acc_op),
      .addr_q(addr_q), .wdata_q(wdata_q),
      .busy(busy)
   );

   assign rd_go = accept && (acc_op == HSM_OP_RD);
   assign wr_go = accept && (acc_op == HSM_OP_WR);

   hsm_delay #(.LAT(READ_LATENCY)) u_rd_dly (
      .clk(clk), .rst(rst), .go(rd_go), .fin(rd_fin)
   );
   hsm_delay #(.LAT(WRITE_LATENCY)) u_wr_dly (
      .clk(clk), .rst(rst), .go(wr_go), .fin(wr_fin)
   );

   // single-cycle paths complete on the accepting edge, so they use live inputs
   if (READ_LATENCY == 1) begin : g_rd_live
      assign rd_addr = addr;
   end else begin : g_rd_held
      assign rd_addr = addr_q;
   end

   if (WRITE_LATENCY == 1) begin : g_wr_live
      assign wr_addr = addr;
      assign wr_word = wdata;
   end else begin : g_wr_held
      assign wr_addr = addr_q;
      assign wr_word = wdata_q;
   end

   hsm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk(clk), .rst(rst),
      .we(wr_fin), .waddr(wr_addr), .wdata(wr_word),
      .re(rd_fin), .raddr(rd_addr), .rdata(rdata)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_done <= 1'b0;
         wr_done <= 1'b0;
      end else begin
         rd_done <= rd_fin;
         wr_done <= wr_fin;
      end
   end

   // R3: never two completions at once
   a_r3_done_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0({rd_done, wr_done}));
   // R3: pulses are one cycle wide
   a_r3_rd_pulse: assert property (@(posedge clk) disable iff (rst)
      rd_done |=> !rd_done);
   a_r3_wr_pulse: assert property (@(posedge clk) disable iff (rst)
      wr_done |=> !wr_done);
   // R5: a simultaneous request pair yields a write, never a read
   a_r5_write_wins: assert property (@(posedge clk) disable iff (rst)
      (rd_start && wr_start && !busy) |=> (busy && !rd_done));
   // R7: read data moves only on a read completion
   a_r7_rdata_hold: assert property (@(posedge clk) disable iff (rst)
      !$stable(rdata) |-> rd_done);
endmodule

// File: tb/hsm_mem_test.sv
module hsm_mem_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 6;
   localparam int DW = 32;
   localparam int VW = 1 + AW + DW;
   localparam int NVEC = 8;
   localparam int LAT_SLOW = 3;

   // vector: {is_write, address, data}; reads expect data
   localparam logic [VW-1:0] VEC [NVEC] = '{
      {1'b1, 6'd0,  32'hA5A5_0001},
      {1'b1, 6'd5,  32'h1234_5678},
      {1'b1, 6'd33, 32'hDEAD_BEEF},
      {1'b1, 6'd63, 32'h0F0F_F0F0},
      {1'b0, 6'd63, 32'h0F0F_F0F0},
      {1'b0, 6'd0,  32'hA5A5_0001},
      {1'b0, 6'd33, 32'hDEAD_BEEF},
      {1'b0, 6'd5,  32'h1234_5678}
   };

   logic clk = 1'b0;
   logic rst;
   logic [1:0] rd_s, wr_s;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata;
   logic [DW-1:0] rdata0, rdata1;
   logic rd_done0, rd_done1, wr_done0, wr_done1, busy0, busy1;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hsm_mem #(.ADDR_W(AW), .DATA_W(DW)) uut (
      .clk(clk), .rst(rst), .rd_start(rd_s[0]), .wr_start(wr_s[0]),
      .addr(addr), .wdata(wdata), .rdata(rdata0),
      .rd_done(rd_done0), .wr_done(wr_done0), .busy(busy0)
   );

   hsm_mem #(.ADDR_W(AW), .DATA_W(DW),
             .READ_LATENCY(LAT_SLOW), .WRITE_LATENCY(LAT_SLOW)) uut_slow (
      .clk(clk), .rst(rst), .rd_start(rd_s[1]), .wr_start(wr_s[1]),
      .addr(addr), .wdata(wdata), .rdata(rdata1),
      .rd_done(rd_done1), .wr_done(wr_done1), .busy(busy1)
   );

   function automatic logic [DW-1:0] q_rdata(int w);
      return (w == 1) ? rdata1 : rdata0;
   endfunction
   function automatic logic q_rdone(int w);
      return (w == 1) ? rd_done1 : rd_done0;
   endfunction
   function automatic logic q_wdone(int w);
      return (w == 1) ? wr_done1 : wr_done0;
   endfunction
   function automatic logic q_busy(int w);
      return (w == 1) ? busy1 : busy0;
   endfunction
   function automatic int lat_of(int w);
      return (w == 1) ? LAT_SLOW : 1;
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // issue one request on instance w, wait for its done, return cycles taken
   task automatic run_op(input int w, input bit is_wr,
                         input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output int lat);
      addr  = a;
      wdata = d;
      if (is_wr) wr_s[w] = 1'b1; else rd_s[w] = 1'b1;
      @(negedge clk);
      rd_s = '0;
      wr_s = '0;
      lat = 1;
      while (!(is_wr ? q_wdone(w) : q_rdone(w)) && lat < 40) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic do_read(input int w, input logic [AW-1:0] a,
                          input logic [DW-1:0] exp, input string req);
      int lat;
      run_op(w, 1'b0, a, '0, lat);
      chk(lat == lat_of(w), "R1 read latency", 64'(lat), 64'(lat_of(w)));
      chk(q_rdata(w) == exp, req, 64'(q_rdata(w)), 64'(exp));
      @(negedge clk);
      chk(!q_busy(w), "R4 busy low after done", 64'(q_busy(w)), 64'd0);
   endtask

   task automatic do_write(input int w, input logic [AW-1:0] a,
                           input logic [DW-1:0] d);
      int lat;
      run_op(w, 1'b1, a, d, lat);
      chk(lat == lat_of(w), "R2 write latency", 64'(lat), 64'(lat_of(w)));
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      int seen;
      int lat;
      rst   = 1'b1;
      rd_s  = '0;
      wr_s  = '0;
      addr  = '0;
      wdata = '0;
      repeat (4) @(negedge clk);

      // R8: reset state
      for (int w = 0; w < 2; w++) begin
         chk(!q_busy(w) && !q_rdone(w) && !q_wdone(w), "R8 reset idle",
             64'({q_busy(w), q_rdone(w), q_wdone(w)}), 64'd0);
         chk(q_rdata(w) == '0, "R8 reset rdata", 64'(q_rdata(w)), 64'd0);
      end
      rst = 1'b0;
      @(negedge clk);

      // table walk on both builds (R1, R2, R9)
      for (int w = 0; w < 2; w++) begin
         for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][VW-1])
               do_write(w, VEC[i][DW+AW-1:DW], VEC[i][DW-1:0]);
            else
               do_read(w, VEC[i][DW+AW-1:DW], VEC[i][DW-1:0], "R1 read data");
         end
      end

      // R9: the slow build takes two extra cycles
      run_op(1, 1'b0, 6'd5, '0, lat);
      chk(lat == 1 + 2, "R9 two extra cycles", 64'(lat), 64'd3);
      @(negedge clk);

      // R4: write during a busy read is dropped
      addr = 6'd0;
      rd_s[1] = 1'b1;
      @(negedge clk);
      rd_s = '0;
      chk(busy1, "R4 busy after accept", 64'(busy1), 64'd1);
      addr = 6'd0;
      wdata = 32'hBAD0_BAD0;
      wr_s[1] = 1'b1;
      @(negedge clk);
      wr_s = '0;
      seen = 0;
      for (int k = 0; k < 8; k++) begin
         if (wr_done1) seen++;
         @(negedge clk);
      end
      chk(seen == 0, "R4 busy request ignored", 64'(seen), 64'd0);
      do_read(1, 6'd0, 32'hA5A5_0001, "R4 array untouched");

      // R5: simultaneous read and write on the fast build
      addr = 6'd7;
      wdata = 32'h7777_0007;
      rd_s[0] = 1'b1;
      wr_s[0] = 1'b1;
      @(negedge clk);
      rd_s = '0;
      wr_s = '0;
      chk(wr_done0 && !rd_done0, "R5 write wins",
          64'({wr_done0, rd_done0}), 64'b10);
      @(negedge clk);
      chk(!rd_done0, "R5 read dropped", 64'(rd_done0), 64'd0);
      @(negedge clk);
      do_read(0, 6'd7, 32'h7777_0007, "R5 written word");

      // R6: inputs change after acceptance on the slow build
      addr = 6'd10;
      wdata = 32'h1010_1010;
      wr_s[1] = 1'b1;
      @(negedge clk);
      wr_s = '0;
      addr = 6'd33;
      wdata = 32'h3333_3333;
      while (!wr_done1) @(negedge clk);
      @(negedge clk);
      do_read(1, 6'd10, 32'h1010_1010, "R6 latched write");
      do_read(1, 6'd33, 32'hDEAD_BEEF, "R6 other word intact");

      // R7: rdata holds across a later write; R2 new value then visible
      do_read(1, 6'd10, 32'h1010_1010, "R7 setup read");
      run_op(1, 1'b1, 6'd10, 32'h2020_2020, lat);
      chk(rdata1 == 32'h1010_1010, "R7 rdata held", 64'(rdata1), 64'h1010_1010);
      @(negedge clk);
      chk(rdata1 == 32'h1010_1010, "R7 rdata still held", 64'(rdata1), 64'h1010_1010);
      do_read(1, 6'd10, 32'h2020_2020, "R2 read after write");

      // R8: reset mid-flight cancels the write, keeps stored words
      addr = 6'd63;
      wdata = 32'h5555_AAAA;
      wr_s[1] = 1'b1;
      @(negedge clk);
      wr_s = '0;
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk(!busy1 && !wr_done1, "R8 reset cancels", 64'({busy1, wr_done1}), 64'd0);
      seen = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (wr_done1 || busy1) seen++;
      end
      chk(seen == 0, "R8 no late done", 64'(seen), 64'd0);
      do_read(1, 6'd63, 32'h0F0F_F0F0, "R8 contents kept slow");
      do_read(0, 6'd7, 32'h7777_0007, "R8 contents kept fast");

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule